// File: doc/BRIEF.md
# Block-Transfer Address and Mask Generator

This block sequences the addresses for a rectangular block copy that uses three source channels (A, B, C) and one destination channel (D). Each channel has a 20-bit byte pointer and a signed 16-bit line modulo, both written through a small register port. Writing the size register starts an operation. The block then walks the rectangle one word per clock, left to right and then line by line. For every enabled channel it presents that channel's current address.

A pointer moves forward by one word (2 bytes) after each word. At the end of each line, each channel's own modulo is also added. Because the pointers are left where they end, a later operation continues from that point unless software reloads them. Source A data passes through a masking stage. That stage clears bits on the first word and on the last word of every line, using two separate mask registers.

Combining the data, shifting it and arbitrating for memory are done by the neighbouring logic.

Top module: `blit_addr_gen`

## Requirements
- R1: Pointers are loaded through the register port. Select 0..3 writes data[3:0] to pointer bits 19:16 of channel A, B, C, D. Select 4..7 writes data[15:1] to pointer bits 15:1 of the same channels, and bit 0 is forced to 0. Select 8..11 writes the channel modulo, again with bit 0 forced to 0. Select 12 writes the first-word mask, select 13 the last-word mask and select 14 the size. The first word of an operation presents the loaded pointer.
- R2: Within a line, an enabled channel's address rises by 2 from one word to the next.
- R3: After the last word of a line, an enabled channel's pointer advances by 2 plus its own sign-extended modulo. Arithmetic wraps modulo 2^20.
- R4: When an operation ends, each pointer holds the last address used plus 2 plus its modulo. The next operation starts from that value.
- R5: On the first word of each line (column 0), a_masked_o equals a_data_i ANDed with the first-word mask.
- R6: On the last word of each line, a_masked_o is ANDed with the last-word mask. When a line is one word wide, both masks apply to that word. On middle words, and while idle, the data passes unchanged.
- R7: A zero bit in either mask forces that output bit to zero. Masking never sets a bit that a_data_i does not have.
- R8: Writing the size register while idle raises busy_o on the next clock. The size data holds the width in bits 5:0 and the height in bits 15:6. busy_o stays high for exactly width × height cycles, one word per cycle.
- R9: A width field of 0 means 64 words, and a height field of 0 means 1024 lines.
- R10: done_o is a single-cycle pulse in the first cycle after the final word, and busy_o is low in that cycle.
- R11: A channel whose enable bit is low has addr_valid_o low for that bit. Its pointer does not move.
- R12: Register writes, including size writes, are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 4 | Register select (see R1) |
| wr_data_i | input | 16 | Register write data |
| chan_en_i | input | 4 | Channel enables, bit 0 = A through bit 3 = D |
| a_data_i | input | 16 | Source A data word |
| a_masked_o | output | 16 | Source A data after masking |
| addr_a_o | output | 20 | Source A byte address |
| addr_b_o | output | 20 | Source B byte address |
| addr_c_o | output | 20 | Source C byte address |
| addr_d_o | output | 20 | Destination byte address |
| addr_valid_o | output | 4 | Per-channel address valid |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse after the final word |

## Verification
The hardest state to reach is a register write that lands in the middle of a running operation. The bench keeps its write task aligned to the word cadence. It starts a two-by-two operation and then issues a pointer write, a second size write and a mask write on consecutive words. It then checks that the operation ends on its original count, and that the following operation still uses the modelled pointers and masks. Carry-over of the final pointer is a second hard case. After each table case, a one-word operation runs without any reload, which exposes both the end-of-operation modulo and the untouched pointers of disabled channels.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int NCH = 4;
  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_PTH  = 4'd0;   // +channel
  localparam logic [SEL_W-1:0] SEL_PTL  = 4'd4;   // +channel
  localparam logic [SEL_W-1:0] SEL_MOD  = 4'd8;   // +channel
  localparam logic [SEL_W-1:0] SEL_FWM  = 4'd12;
  localparam logic [SEL_W-1:0] SEL_LWM  = 4'd13;
  localparam logic [SEL_W-1:0] SEL_SIZE = 4'd14;
endpackage

// File: rtl/blit_chan.sv
module blit_chan
  import blit_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CH     = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic              en_i,
  input  logic              line_end_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);
  localparam logic [SEL_W-1:0] MY_PTH = SEL_PTH + SEL_W'(CH);
  localparam logic [SEL_W-1:0] MY_PTL = SEL_PTL + SEL_W'(CH);
  localparam logic [SEL_W-1:0] MY_MOD = SEL_MOD + SEL_W'(CH);

  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] mod_q;
  logic [ADDR_W-1:0] mod_ext, step;

  assign mod_ext = {{HI_W{mod_q[DATA_W-1]}}, mod_q};
  assign step    = line_end_i ? WORD_BYTES + mod_ext : WORD_BYTES;
  assign addr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      mod_q <= '0;
    end else if (busy_i) begin
      if (en_i) ptr_q <= ptr_q + step;
    end else if (wr_en_i) begin
      if (wr_sel_i == MY_PTH) ptr_q[ADDR_W-1:DATA_W] <= wr_data_i[HI_W-1:0];
      if (wr_sel_i == MY_PTL) ptr_q[DATA_W-1:0] <= {wr_data_i[DATA_W-1:1], 1'b0};
      if (wr_sel_i == MY_MOD) mod_q <= {wr_data_i[DATA_W-1:1], 1'b0};
    end
  end
endmodule

// File: rtl/blit_seq.sv
module blit_seq #(
  parameter int WID_W = 6,
  parameter int HGT_W = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [WID_W+HGT_W-1:0] size_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   first_o,
  output logic                   last_o
);
  localparam logic [WID_W:0] W_ONE = (WID_W+1)'(1);
  localparam logic [HGT_W:0] H_ONE = (HGT_W+1)'(1);

  logic [WID_W:0] width_q, col_q, width_dec;
  logic [HGT_W:0] height_q, row_q, height_dec;
  logic [WID_W-1:0] w_fld;
  logic [HGT_W-1:0] h_fld;

  assign w_fld = size_i[WID_W-1:0];
  assign h_fld = size_i[WID_W+HGT_W-1:WID_W];
  // zero field selects the maximum count
  assign width_dec  = (w_fld == '0) ? {1'b1, {WID_W{1'b0}}} : {1'b0, w_fld};
  assign height_dec = (h_fld == '0) ? {1'b1, {HGT_W{1'b0}}} : {1'b0, h_fld};

  assign first_o = busy_o && (col_q == '0);
  assign last_o  = busy_o && (col_q == width_q - W_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      width_q  <= '0;
      height_q <= '0;
      col_q    <= '0;
      row_q    <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_o   <= 1'b1;
        width_q  <= width_dec;
        height_q <= height_dec;
        col_q    <= '0;
        row_q    <= '0;
      end else if (busy_o) begin
        if (last_o) begin
          col_q <= '0;
          if (row_q == height_q - H_ONE) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            row_q <= row_q + H_ONE;
          end
        end else begin
          col_q <= col_q + W_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/blit_mask.sv
module blit_mask #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] first_mask_i,
  input  logic [DATA_W-1:0] last_mask_i,
  input  logic              first_i,
  input  logic              last_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] fm, lm;
  assign fm     = first_i ? first_mask_i : '1;
  assign lm     = last_i  ? last_mask_i  : '1;
  assign data_o = data_i & fm & lm;
endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
  import blit_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int WID_W  = 6,
  parameter int HGT_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NCH-1:0]    chan_en_i,
  input  logic [DATA_W-1:0] a_data_i,
  output logic [DATA_W-1:0] a_masked_o,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [ADDR_W-1:0] addr_b_o,
  output logic [ADDR_W-1:0] addr_c_o,
  output logic [ADDR_W-1:0] addr_d_o,
  output logic [NCH-1:0]    addr_valid_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_w [NCH];
  logic [DATA_W-1:0] fwm_q, lwm_q;
  logic first_w, last_w, start_w, cfg_wr;

  assign cfg_wr  = wr_en_i && !busy_o;
  assign start_w = cfg_wr && (wr_sel_i == SEL_SIZE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwm_q <= '1;
      lwm_q <= '1;
    end else if (cfg_wr) begin
      if (wr_sel_i == SEL_FWM) fwm_q <= wr_data_i;
      if (wr_sel_i == SEL_LWM) lwm_q <= wr_data_i;
    end
  end

  blit_seq #(.WID_W(WID_W), .HGT_W(HGT_W)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_w),
    .size_i (wr_data_i[WID_W+HGT_W-1:0]),
    .busy_o (busy_o),
    .done_o (done_o),
    .first_o(first_w),
    .last_o (last_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    blit_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH(g)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .busy_i    (busy_o),
      .en_i      (chan_en_i[g]),
      .line_end_i(last_w),
      .addr_o    (addr_w[g])
    );
  end

  blit_mask #(.DATA_W(DATA_W)) i_mask (
    .data_i      (a_data_i),
    .first_mask_i(fwm_q),
    .last_mask_i (lwm_q),
    .first_i     (first_w),
    .last_i      (last_w),
    .data_o      (a_masked_o)
  );

  assign addr_a_o     = addr_w[0];
  assign addr_b_o     = addr_w[1];
  assign addr_c_o     = addr_w[2];
  assign addr_d_o     = addr_w[3];
  assign addr_valid_o = {NCH{busy_o}} & chan_en_i;
endmodule

// File: rtl/blit_addr_gen_chk.sv
module blit_addr_gen_chk
  import blit_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [SEL_W-1:0]  wr_sel_i,
  input logic [DATA_W-1:0] a_data_i,
  input logic [DATA_W-1:0] a_masked_o,
  input logic [ADDR_W-1:0] addr_a_o,
  input logic [NCH-1:0]    addr_valid_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              last_w
);
  assert_start_from_size_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i && (wr_sel_i == SEL_SIZE)));

  assert_done_on_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_after_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_step_two_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && addr_valid_o[0] && !last_w) |=> (addr_a_o == $past(addr_a_o) + ADDR_W'(2)));

  assert_mask_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_masked_o & ~a_data_i) == '0);
endmodule

bind blit_addr_gen blit_addr_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .a_data_i    (a_data_i),
  .a_masked_o  (a_masked_o),
  .addr_a_o    (addr_a_o),
  .addr_valid_o(addr_valid_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .last_w      (last_w)
);

// File: tb/test_blit_addr_gen.sv
module test_blit_addr_gen;
  import blit_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int NCASE = 5;
  // {base[19:0], mod[15:0], width[5:0], height[9:0], enables[3:0]}
  localparam logic [55:0] CASES [NCASE] = '{
    {20'h01000, 16'h0000, 6'd3, 10'd2, 4'hF},
    {20'h0FFF0, 16'h0004, 6'd2, 10'd3, 4'hF},
    {20'h20000, 16'hFFF8, 6'd4, 10'd2, 4'h5},
    {20'h00100, 16'h0010, 6'd1, 10'd4, 4'hF},
    {20'hFFFFC, 16'h0002, 6'd2, 10'd2, 4'hA}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [SEL_W-1:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0, a_data = '0;
  logic [NCH-1:0] chan_en = '0;
  logic [DW-1:0] a_masked;
  logic [AW-1:0] addr_a, addr_b, addr_c, addr_d;
  logic [NCH-1:0] addr_valid;
  logic busy, done;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_ptr [NCH];
  logic [AW-1:0] exp_mod [NCH];
  logic [DW-1:0] exp_fwm = '1, exp_lwm = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  blit_addr_gen i_blit_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .chan_en_i(chan_en), .a_data_i(a_data),
    .a_masked_o(a_masked), .addr_a_o(addr_a), .addr_b_o(addr_b),
    .addr_c_o(addr_c), .addr_d_o(addr_d), .addr_valid_o(addr_valid),
    .busy_o(busy), .done_o(done)
  );

  function automatic logic [AW-1:0] addr_of(input int ch);
    case (ch)
      0: return addr_a;
      1: return addr_b;
      2: return addr_c;
      default: return addr_d;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // called at negedge+1, returns at the next negedge+1
  task automatic wr(input logic [SEL_W-1:0] sel, input logic [DW-1:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic load_chan(input int ch, input logic [AW-1:0] ptr, input logic [DW-1:0] md);
    wr(SEL_PTH + SEL_W'(ch), {12'h000, ptr[19:16]});
    wr(SEL_PTL + SEL_W'(ch), ptr[15:0]);
    wr(SEL_MOD + SEL_W'(ch), md);
    exp_ptr[ch] = ptr;
    exp_mod[ch] = {{4{md[15]}}, md};
  endtask

  task automatic run_op(input logic [5:0] w, input logic [9:0] h, input logic [3:0] en);
    int weff, heff;
    logic [DW-1:0] em;
    weff = (w == 0) ? 64 : int'(w);
    heff = (h == 0) ? 1024 : int'(h);
    chan_en = en;
    wr(SEL_SIZE, {h, w});
    for (int r = 0; r < heff; r++) begin
      for (int c = 0; c < weff; c++) begin
        a_data = 16'hFFFF ^ DW'(c * 3 + r);
        #1;
        check("R8 busy during op", 32'(busy), 32'd1);
        em = a_data;
        if (c == 0) em = em & exp_fwm;          // R5
        if (c == weff - 1) em = em & exp_lwm;   // R6
        check("R5/R6 mask", 32'(a_masked), 32'(em));
        for (int ch = 0; ch < NCH; ch++) begin
          if (en[ch]) begin
            check("R1/R2/R3 address", 32'(addr_of(ch)), 32'(exp_ptr[ch]));
            exp_ptr[ch] = exp_ptr[ch] + AW'(2) + ((c == weff - 1) ? exp_mod[ch] : '0);
          end
          check("R11 valid", 32'(addr_valid[ch]), 32'(en[ch]));
        end
        @(negedge clk); #1;
      end
    end
    check("R8 busy low after w*h", 32'(busy), 32'd0);
    check("R10 done pulse", 32'(done), 32'd1);
    @(negedge clk); #1;
    check("R10 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [55:0] e;
    logic [AW-1:0] base;
    logic [DW-1:0] md;
    for (int ch = 0; ch < NCH; ch++) begin exp_ptr[ch] = '0; exp_mod[ch] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 reset busy", 32'(busy), 32'd0);
    check("R10 reset done", 32'(done), 32'd0);
    check("R11 reset valid", 32'(addr_valid), 32'd0);
    a_data = 16'h5AA5; #1;
    check("R6 idle passthrough", 32'(a_masked), 32'h5AA5);
    @(negedge clk); #1;

    wr(SEL_FWM, 16'hF0F3); exp_fwm = 16'hF0F3;
    wr(SEL_LWM, 16'h3FCF); exp_lwm = 16'h3FCF;

    // table of cases; each followed by an unreloaded 1x1 op (R4, R11)
    for (int k = 0; k < NCASE; k++) begin
      e = CASES[k];
      base = e[55:36];
      md = e[35:20];
      for (int ch = 0; ch < NCH; ch++)
        load_chan(ch, base + AW'(ch * 'h4000), md + DW'(2 * ch));
      run_op(e[19:14], e[13:4], e[3:0]);
      run_op(6'd1, 10'd1, 4'hF);  // R4 continuation
    end

    // R9: zero fields select maximum
    run_op(6'd0, 10'd1, 4'h9);
    run_op(6'd1, 10'd0, 4'h2);

    // R12: writes during an operation are ignored
    chan_en = 4'hF;
    wr(SEL_SIZE, {10'd2, 6'd2});
    wr(SEL_PTL, 16'h1234);
    wr(SEL_SIZE, {10'd1, 6'd1});
    wr(SEL_FWM, 16'h0000);
    check("R12 op length unchanged", 32'(busy), 32'd1);
    @(negedge clk); #1;
    check("R12 ends on original count", 32'(busy), 32'd0);
    check("R12 done", 32'(done), 32'd1);
    @(negedge clk); #1;
    for (int ch = 0; ch < NCH; ch++)
      exp_ptr[ch] = exp_ptr[ch] + AW'(8) + exp_mod[ch] + exp_mod[ch];
    run_op(6'd1, 10'd1, 4'hF);

    summary();
  end
endmodule